// File: doc/BRIEF.md
# SDRAM Mode Register Programming Unit

This block is the device-side handling of the load-mode command in a low-power DDR SDRAM. It watches the command strobes on every rising clock edge. When a load-mode command is recognised, it stores the address bus into either the main mode register or the extended mode register, depending on the bank-address pins. The stored main word is decoded into burst length, burst ordering, read latency and a test-mode bit. Codes that have no defined meaning are flagged.

The unit also guards its own timing. After each accepted write, a busy window blocks further commands. The window is short while the device is still being brought up and longer once the main register has been programmed for the first time. Any command that arrives inside the window is reported as a violation. A load-mode command is refused if any bank is open. Rewriting the main register returns the extended register to its default contents and marks it as needing a fresh write.

Top module: `mrs_prog_unit`

## Requirements
- R1: A command is seen only when `cke` is high on the current edge and was also high on the previous edge, and `cs_n` is low. A load-mode command additionally needs `ras_n`, `cas_n` and `we_n` low. With `cke` low, or `cke` just rising, the strobes have no effect on any output.
- R2: An accepted main write (`ba` = 00) stores `addr` into `mode_word`, visible from the cycle after the edge, and sets `cfg_written`.
- R3: Burst length is taken from `mode_word[2:0]`. Code 001 gives 2, 010 gives 4 and 011 gives 8. Any other code gives `burst_len` = 0 with `bl_reserved` = 1.
- R4: `burst_interleave` equals `mode_word[3]` (1 = interleaved), and `test_mode` equals `mode_word[7]`.
- R5: Read latency is taken from `mode_word[6:4]`. Only 011 is legal and gives `cas_latency` = 3. Any other code gives 0 with `cl_reserved` = 1.
- R6: `config_valid` is 1 only when `cfg_written` is 1 and neither `bl_reserved` nor `cl_reserved` is set. A reserved code is still stored in `mode_word`.
- R7: A write with `ba` = 10 targets the extended register. It stores `addr` in `ext_mode` and sets `ext_valid`. A write with `ba` = 01 or 11 changes no register, starts no busy window, and pulses `tgt_err` high for one cycle.
- R8: A write that is not busy and has a legal target, issued while any `bank_idle` bit is 0, is refused. `bank_err` pulses for one cycle and both registers keep their values. The order of checks is: busy first, then target, then bank state.
- R9: An accepted main write sets `ext_mode` to its default (all zero) and clears `ext_valid`.
- R10: After any accepted write, `busy` is high for N-1 cycles starting the next cycle. N is 2 until the first accepted main write and 4 after it. A command on the edge N cycles after the write is legal.
- R11: Any command seen per R1 (not all three of `ras_n`, `cas_n`, `we_n` high) while `busy` is high pulses `timing_err` for one cycle. A load-mode command seen in that window is not applied.
- R12: A synchronous active-high `rst` clears `cfg_written`, `ext_valid`, `busy`, all error pulses and the initialized state, so that the next write uses N = 2 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cke | input | 1 | Clock enable |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | 12 | Address bus, the mode word |
| ba | input | 2 | Bank address, selects the target register |
| bank_idle | input | 4 | One bit per bank, 1 = idle |
| mode_word | output | 12 | Stored main mode word |
| burst_len | output | 4 | Decoded burst length (0 = reserved) |
| burst_interleave | output | 1 | 1 = interleaved ordering |
| cas_latency | output | 3 | Decoded read latency (0 = reserved) |
| test_mode | output | 1 | Test-mode bit |
| bl_reserved | output | 1 | Burst-length code is reserved |
| cl_reserved | output | 1 | Latency code is reserved |
| cfg_written | output | 1 | Main register written since reset |
| config_valid | output | 1 | Settings usable |
| ext_mode | output | 12 | Stored extended mode word |
| ext_valid | output | 1 | Extended register written since last main write |
| busy | output | 1 | Post-write lockout window |
| timing_err | output | 1 | One-cycle pulse: command inside lockout |
| bank_err | output | 1 | One-cycle pulse: write refused, bank open |
| tgt_err | output | 1 | One-cycle pulse: reserved target register |

## Verification
Most internal faults show at the ports one cycle after the offending edge:
- A wrong capture or decode appears as a wrong `mode_word` or wrong decoded field.
- A wrong lockout counter shows as a `busy` window one or more cycles too long or too short.
- A lost initialized state shows as a 4-cycle window where a 2-cycle one is due, or the reverse.
- A lost refusal shows as `mode_word` changing when it must hold, together with a missing error pulse.

A stale extended register after a main write appears immediately as `ext_valid` still high.

// File: rtl/mrs_pkg.sv
package mrs_pkg;
  localparam int BL_LSB = 0;
  localparam int BT_BIT = 3;
  localparam int CL_LSB = 4;
  localparam int TM_BIT = 7;

  typedef enum logic [1:0] {
    TGT_MAIN = 2'b00,
    TGT_RSV1 = 2'b01,
    TGT_EXT  = 2'b10,
    TGT_RSV3 = 2'b11
  } mrs_tgt_e;

  typedef struct packed {
    logic [3:0] burst_len;
    logic       interleave;
    logic [2:0] cas_lat;
    logic       test_mode;
    logic       bl_rsv;
    logic       cl_rsv;
  } mode_fields_t;

  // burst length in beats, 0 for a reserved code
  function automatic logic [3:0] bl_from_code(input logic [2:0] code);
    case (code)
      3'b001:  return 4'd2;
      3'b010:  return 4'd4;
      3'b011:  return 4'd8;
      default: return 4'd0;
    endcase
  endfunction

  // read latency in cycles, 0 for a reserved code
  function automatic logic [2:0] cl_from_code(input logic [2:0] code);
    return (code == 3'b011) ? 3'd3 : 3'd0;
  endfunction
endpackage

// File: rtl/mrs_cmd_decode.sv
module mrs_cmd_decode (
  input  logic clk,
  input  logic rst,
  input  logic cke,
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output logic any_cmd,
  output logic lmr_cmd
);
  logic cke_q;
  logic live;

  always_ff @(posedge clk) begin
    if (rst) cke_q <= 1'b0;
    else     cke_q <= cke;
  end

  // R1: clock enable must be high on this edge and the previous one
  assign live    = cke & cke_q & ~cs_n;
  assign any_cmd = live & ~(ras_n & cas_n & we_n);
  assign lmr_cmd = live & ~ras_n & ~cas_n & ~we_n;

  assert property (@(posedge clk) disable iff (rst)
    !cke_q |-> !any_cmd) else $error("assert_cke_gate_R1");
endmodule

// File: rtl/mrs_busy_timer.sv
module mrs_busy_timer #(
  parameter int MRD_INIT = 2,
  parameter int MRD_RUN  = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic start_main,
  output logic busy
);
  localparam int CW = $clog2(MRD_RUN + 1);

  logic [CW-1:0] cnt_q;
  logic          init_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      init_q <= 1'b0;
    end else begin
      if (start)
        cnt_q <= init_q ? CW'(MRD_RUN - 1) : CW'(MRD_INIT - 1);
      else if (cnt_q != '0)
        cnt_q <= cnt_q - 1'b1;
      if (start_main) init_q <= 1'b1;
    end
  end

  assign busy = (cnt_q != '0);

  assert property (@(posedge clk) disable iff (rst)
    start |=> busy) else $error("assert_busy_start_R10");
  assert property (@(posedge clk) disable iff (rst)
    cnt_q < CW'(MRD_RUN)) else $error("assert_busy_bound_R10");
  assert property (@(posedge clk) disable iff (rst)
    (busy && !start) |=> (cnt_q == $past(cnt_q) - 1'b1))
    else $error("assert_busy_count_R10");
endmodule

// File: rtl/mrs_field_decode.sv
module mrs_field_decode
  import mrs_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] word,
  output mode_fields_t      fields
);
  logic [2:0] bl_code;
  logic [2:0] cl_code;

  assign bl_code = word[BL_LSB +: 3];
  assign cl_code = word[CL_LSB +: 3];

  always_comb begin
    fields.burst_len  = bl_from_code(bl_code);
    fields.interleave = word[BT_BIT];
    fields.cas_lat    = cl_from_code(cl_code);
    fields.test_mode  = word[TM_BIT];
    fields.bl_rsv     = (fields.burst_len == 4'd0);
    fields.cl_rsv     = (fields.cas_lat == 3'd0);
  end
endmodule

// File: rtl/mrs_prog_unit.sv
module mrs_prog_unit
  import mrs_pkg::*;
#(
  parameter int                ADDR_W      = 12,
  parameter int                BANKS       = 4,
  parameter int                MRD_INIT    = 2,
  parameter int                MRD_RUN     = 4,
  parameter logic [ADDR_W-1:0] EXT_DEFAULT = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cke,
  input  logic              cs_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        ba,
  input  logic [BANKS-1:0]  bank_idle,
  output logic [ADDR_W-1:0] mode_word,
  output logic [3:0]        burst_len,
  output logic              burst_interleave,
  output logic [2:0]        cas_latency,
  output logic              test_mode,
  output logic              bl_reserved,
  output logic              cl_reserved,
  output logic              cfg_written,
  output logic              config_valid,
  output logic [ADDR_W-1:0] ext_mode,
  output logic              ext_valid,
  output logic              busy,
  output logic              timing_err,
  output logic              bank_err,
  output logic              tgt_err
);
  logic any_cmd, lmr_cmd;
  logic all_idle, rsv_tgt;
  logic viol, wr_ok, reject_tgt, reject_bank, accept_main, accept_ext;
  mode_fields_t fields;

  mrs_cmd_decode u_cmd (
    .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .any_cmd(any_cmd), .lmr_cmd(lmr_cmd)
  );

  // named events, priority: busy, then target, then bank state
  assign all_idle    = &bank_idle;
  assign rsv_tgt     = (ba == TGT_RSV1) || (ba == TGT_RSV3);
  assign viol        = any_cmd & busy;
  assign wr_ok       = lmr_cmd & ~busy;
  assign reject_tgt  = wr_ok & rsv_tgt;
  assign reject_bank = wr_ok & ~rsv_tgt & ~all_idle;
  assign accept_main = wr_ok & all_idle & (ba == TGT_MAIN);
  assign accept_ext  = wr_ok & all_idle & (ba == TGT_EXT);

  mrs_busy_timer #(.MRD_INIT(MRD_INIT), .MRD_RUN(MRD_RUN)) u_timer (
    .clk(clk), .rst(rst), .start(accept_main | accept_ext),
    .start_main(accept_main), .busy(busy)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_word   <= '0;
      cfg_written <= 1'b0;
      ext_mode    <= EXT_DEFAULT;
      ext_valid   <= 1'b0;
      timing_err  <= 1'b0;
      bank_err    <= 1'b0;
      tgt_err     <= 1'b0;
    end else begin
      timing_err <= viol;
      bank_err   <= reject_bank;
      tgt_err    <= reject_tgt;
      if (accept_main) begin
        mode_word   <= addr;
        cfg_written <= 1'b1;
        ext_mode    <= EXT_DEFAULT;
        ext_valid   <= 1'b0;
      end else if (accept_ext) begin
        ext_mode  <= addr;
        ext_valid <= 1'b1;
      end
    end
  end

  mrs_field_decode #(.ADDR_W(ADDR_W)) u_fields (.word(mode_word), .fields(fields));

  assign burst_len        = fields.burst_len;
  assign burst_interleave = fields.interleave;
  assign cas_latency      = fields.cas_lat;
  assign test_mode        = fields.test_mode;
  assign bl_reserved      = fields.bl_rsv;
  assign cl_reserved      = fields.cl_rsv;
  assign config_valid     = cfg_written & ~fields.bl_rsv & ~fields.cl_rsv;

  assert property (@(posedge clk) disable iff (rst)
    accept_main |=> (mode_word == $past(addr)) && cfg_written)
    else $error("assert_capture_R2");
  assert property (@(posedge clk) disable iff (rst)
    accept_ext |=> (ext_mode == $past(addr)) && ext_valid)
    else $error("assert_ext_capture_R7");
  assert property (@(posedge clk) disable iff (rst)
    reject_tgt |=> tgt_err && $stable(mode_word) && $stable(ext_mode) && !busy)
    else $error("assert_tgt_reject_R7");
  assert property (@(posedge clk) disable iff (rst)
    reject_bank |=> bank_err && $stable(mode_word) && $stable(ext_mode))
    else $error("assert_bank_reject_R8");
  assert property (@(posedge clk) disable iff (rst)
    accept_main |=> !ext_valid && (ext_mode == EXT_DEFAULT))
    else $error("assert_ext_clear_R9");
  assert property (@(posedge clk) disable iff (rst)
    viol |=> timing_err && $stable(mode_word) && $stable(ext_mode))
    else $error("assert_violation_R11");
  assert property (@(posedge clk) disable iff (rst)
    $onehot0({viol, reject_tgt, reject_bank, accept_main, accept_ext}))
    else $error("assert_exclusive_R8");
endmodule

// File: tb/mrs_prog_unit_tb_top.sv
module mrs_prog_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cke = 1'b0, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [11:0] addr = '0;
  logic [1:0]  ba = '0;
  logic [3:0]  bank_idle = 4'hF;
  logic [11:0] mode_word, ext_mode;
  logic [3:0]  burst_len;
  logic [2:0]  cas_latency;
  logic burst_interleave, test_mode, bl_reserved, cl_reserved, cfg_written;
  logic config_valid, ext_valid, busy, timing_err, bank_err, tgt_err;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  mrs_prog_unit dut_i (
    .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .addr(addr), .ba(ba), .bank_idle(bank_idle), .mode_word(mode_word),
    .burst_len(burst_len), .burst_interleave(burst_interleave), .cas_latency(cas_latency),
    .test_mode(test_mode), .bl_reserved(bl_reserved), .cl_reserved(cl_reserved),
    .cfg_written(cfg_written), .config_valid(config_valid), .ext_mode(ext_mode),
    .ext_valid(ext_valid), .busy(busy), .timing_err(timing_err), .bank_err(bank_err),
    .tgt_err(tgt_err)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // expected decode, restated from the requirements
  function automatic int exp_bl(input logic [11:0] w);
    if (w[2:0] == 3'b001) return 2;
    if (w[2:0] == 3'b010) return 4;
    if (w[2:0] == 3'b011) return 8;
    return 0;
  endfunction
  function automatic int exp_cl(input logic [11:0] w);
    return (w[6:4] == 3'b011) ? 3 : 0;
  endfunction

  // one command cycle; returns at the following negedge
  task automatic put(input logic r, input logic c, input logic w,
                     input logic [1:0] b, input logic [11:0] a);
    cs_n = 1'b0; ras_n = r; cas_n = c; we_n = w; ba = b; addr = a;
    @(negedge clk);
    cs_n = 1'b1; ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1;
  endtask
  task automatic nop();
    @(negedge clk);
  endtask
  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask
  task automatic busy_len(output int n);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
  endtask
  task automatic check_decode(input string tag, input logic [11:0] w);
    chk({tag, " word R2"}, int'(mode_word), int'(w));
    chk({tag, " bl R3"}, int'(burst_len), exp_bl(w));
    chk({tag, " blrsv R3"}, int'(bl_reserved), int'(exp_bl(w) == 0));
    chk({tag, " bt R4"}, int'(burst_interleave), int'(w[3]));
    chk({tag, " tm R4"}, int'(test_mode), int'(w[7]));
    chk({tag, " cl R5"}, int'(cas_latency), exp_cl(w));
    chk({tag, " clrsv R5"}, int'(cl_reserved), int'(exp_cl(w) == 0));
    chk({tag, " valid R6"}, int'(config_valid), int'(exp_bl(w) != 0 && exp_cl(w) != 0));
  endtask

  task automatic t_reset();
    rst = 1'b1; nop(); nop(); rst = 1'b0; nop();
    chk("reset written R12", int'(cfg_written), 0);
    chk("reset ext R12", int'(ext_valid), 0);
    chk("reset busy R12", int'(busy), 0);
    chk("reset errs R12", int'({timing_err, bank_err, tgt_err}), 0);
    chk("reset valid R12", int'(config_valid), 0);
  endtask

  task automatic t_cke_gate();
    cke = 1'b0;
    put(1'b0, 1'b0, 1'b0, 2'b00, 12'h032);
    chk("cke low R1", int'(cfg_written), 0);
    cke = 1'b1;
    put(1'b0, 1'b0, 1'b0, 2'b00, 12'h032);
    chk("cke rising R1", int'(cfg_written), 0);
    chk("cke rising busy R1", int'(busy), 0);
    nop();
  endtask

  task automatic t_first_write();
    int n;
    put(1'b0, 1'b0, 1'b0, 2'b00, 12'h032);
    chk("first written R2", int'(cfg_written), 1);
    check_decode("first", 12'h032);
    busy_len(n);
    chk("init window R10", n, 1);
  endtask

  task automatic t_ext();
    int n;
    put(1'b0, 1'b0, 1'b0, 2'b10, 12'h005);
    chk("ext word R7", int'(ext_mode), 5);
    chk("ext valid R7", int'(ext_valid), 1);
    chk("ext main kept R7", int'(mode_word), 12'h032);
    busy_len(n);
    chk("run window R10", n, 3);
    put(1'b0, 1'b0, 1'b0, 2'b00, 12'h0BB);
    chk("ext cleared R9", int'(ext_valid), 0);
    chk("ext default R9", int'(ext_mode), 0);
    check_decode("bl8 il tm", 12'h0BB);
    wait_idle();
  endtask

  task automatic t_reserved();
    put(1'b0, 1'b0, 1'b0, 2'b00, 12'h030);
    check_decode("bl rsv", 12'h030);
    wait_idle();
    put(1'b0, 1'b0, 1'b0, 2'b00, 12'h021);
    check_decode("cl rsv", 12'h021);
    wait_idle();
    put(1'b0, 1'b0, 1'b0, 2'b00, 12'h031);
    check_decode("legal again", 12'h031);
    wait_idle();
  endtask

  task automatic t_bank_open();
    bank_idle = 4'b1011;
    put(1'b0, 1'b0, 1'b0, 2'b00, 12'h033);
    chk("open err R8", int'(bank_err), 1);
    chk("open word R8", int'(mode_word), 12'h031);
    chk("open busy R8", int'(busy), 0);
    put(1'b0, 1'b0, 1'b0, 2'b10, 12'h007);
    chk("open ext R8", int'(ext_valid), 0);
    nop();
    chk("open pulse R8", int'(bank_err), 0);
    bank_idle = 4'hF;
  endtask

  task automatic t_bad_target();
    put(1'b0, 1'b0, 1'b0, 2'b01, 12'h033);
    chk("tgt01 err R7", int'(tgt_err), 1);
    chk("tgt01 word R7", int'(mode_word), 12'h031);
    chk("tgt01 busy R7", int'(busy), 0);
    put(1'b0, 1'b0, 1'b0, 2'b11, 12'h033);
    chk("tgt11 err R7", int'(tgt_err), 1);
    chk("tgt11 ext R7", int'(ext_valid), 0);
    nop();
    chk("tgt pulse R7", int'(tgt_err), 0);
  endtask

  task automatic t_violation();
    put(1'b0, 1'b0, 1'b0, 2'b00, 12'h032);
    put(1'b0, 1'b0, 1'b0, 2'b00, 12'h033);
    chk("viol err R11", int'(timing_err), 1);
    chk("viol word R11", int'(mode_word), 12'h032);
    put(1'b0, 1'b1, 1'b1, 2'b00, 12'h000);
    chk("viol act R11", int'(timing_err), 1);
    put(1'b1, 1'b1, 1'b1, 2'b00, 12'h000);
    chk("boundary last busy edge R11", int'(timing_err), 0);
    chk("boundary busy R10", int'(busy), 0);
    put(1'b0, 1'b0, 1'b0, 2'b00, 12'h031);
    chk("boundary accept R10", int'(timing_err), 0);
    chk("boundary word R10", int'(mode_word), 12'h031);
    nop(); nop();
    put(1'b0, 1'b0, 1'b0, 2'b00, 12'h032);
    chk("edge N-1 viol R11", int'(timing_err), 1);
    chk("edge N-1 word R11", int'(mode_word), 12'h031);
    wait_idle();
  endtask

  task automatic t_reset_again();
    int n;
    t_reset();
    put(1'b0, 1'b0, 1'b0, 2'b00, 12'h032);
    busy_len(n);
    chk("post reset window R12", n, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_cke_gate();
    t_first_write();
    t_ext();
    t_reserved();
    t_bank_open();
    t_bad_target();
    t_violation();
    t_reset_again();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule